// File: doc/BRIEF.md
# Multiplexed Bus Target Controller

This block is the target side of a 32-bit parallel bus on which address and data share one set of lines. An initiator opens a transaction by raising its active signal. The clock in which that signal is first seen high is the address phase: the controller samples the address and the command in it. One or more data phases follow. The controller decides whether the cycle belongs to it, raises a claim signal after a configurable decode latency, and then moves one 32-bit word per clock between the bus and a small local memory.

The controller can end a burst early in two ways. In a disconnect it transfers the current word and stops. In a retry it stops in the first data phase without moving any data. Write data is checked against an even-parity bit that arrives one clock after the word it covers, and a mismatch is flagged on an error output. The decode latency, the cache-line setting and the base of the decode window are static configuration inputs. A design parameter makes every Nth claimed transaction end in a retry, so that the initiator's retry handling can be exercised.

Top module: `mux_bus_target`

## Requirements
- R1: The clock in which `ini_active_i` is first sampled high is clock 1 of the transaction. For a claimed cycle, `claim_o` first goes high in clock 2, 3 or 4 when `speed_i` is 0, 1 or 2. The value 3 gives the same timing as 2.
- R2: Only two commands on `cbe_i` are claimed: memory read (4'h6) and memory write (4'h7), and only when the address lies in [`win_base_i`, `win_base_i` + 4*MEM_WORDS). The window is aligned to its own size. Any other command, including the dual-address command 4'hD, or any address outside the window, leaves `claim_o` low for the whole transaction.
- R3: A word is transferred on a rising edge at which both `ini_ready_i` and `tgt_ready_o` are high. Back-to-back ready clocks move one word per clock. A read presents the stored word on `ad_o` with `ad_oe_o` high. A write stores `ad_i` byte lane k (bits 8k+7:8k) only when `cbe_i[k]` is 1.
- R4: The first word uses the word at address bits [5:2] of the address phase. Each later word of the burst uses the next word, 4 bytes higher, in linear order.
- R5: A data phase that uses the last word of the window raises `tgt_stop_o` together with `tgt_ready_o`. That word transfers and the burst ends.
- R6: The supported values of `line_size_i` are 4, 8 and 16. With any other value, every burst transfers exactly one word: the first data phase raises `tgt_stop_o` together with `tgt_ready_o`.
- R7: With RETRY_EVERY = N > 0, the Nth, 2Nth, ... claimed transactions after reset are retried. They raise `tgt_stop_o` and `claim_o` with `tgt_ready_o` low, and no word moves. A repeat of the same transaction counts as a new claim.
- R8: Parity is even over `ad_i`, `cbe_i` and `par_i`. `par_i` is sampled on the edge one clock after a write word transfers. If it does not match, `par_err_o` is high for the one clock that follows that sampling edge. `par_err_o` is low at all other times.
- R9: A transfer with `ini_active_i` low is the last one. After that edge, `claim_o`, `tgt_ready_o` and `tgt_stop_o` are all low. After a retry, or after a disconnect with `ini_active_i` still high, `claim_o` and `tgt_stop_o` stay high until `ini_active_i` is sampled low.
- R10: While `rst_n` is low, `claim_o`, `tgt_ready_o`, `tgt_stop_o`, `ad_oe_o` and `par_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ini_active_i | input | 1 | Initiator transaction active; held low for the final data phase |
| ini_ready_i | input | 1 | Initiator ready in the current data phase |
| ad_i | input | 32 | Address in the address phase, write data in data phases |
| cbe_i | input | 4 | Command in the address phase, active-high byte enables in data phases |
| par_i | input | 1 | Even-parity bit for the previous clock's `ad_i`/`cbe_i` |
| speed_i | input | 2 | Decode latency: 0 fast, 1 medium, 2 or 3 slow |
| line_size_i | input | 8 | Cache-line setting in words |
| win_base_i | input | 32 | Base address of the decode window |
| ad_o | output | 32 | Read data |
| ad_oe_o | output | 1 | Read data on `ad_o` is valid and driven |
| claim_o | output | 1 | The target has claimed the current transaction |
| tgt_ready_o | output | 1 | Target ready in the current data phase |
| tgt_stop_o | output | 1 | Target requests the end of the transaction |
| par_err_o | output | 1 | Write-data parity error flag |

## Verification
The bench opens each kind of cycle under all three decode latencies. It counts the clock in which the claim first appears: a design off by one register would claim a clock early or late. It drives the dual-address command and an address just outside the window, where a loose decoder would claim the cycle. It also runs bursts that reach the last word of the window, where a design missing the limit would wrap and overwrite word 0. Unsupported cache-line values are used to catch a design that keeps bursting. Every fourth claim is retried, so a retry that still moved a word, or released its stop early, shows up as a wrong transfer count or stale read-back data. Bad parity is injected on a two-word write to catch an error flag that comes a clock early, late, or not at all.

// File: rtl/mbt_pkg.sv
package mbt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DATA,
    ST_RETRY,
    ST_HOLD,
    ST_SKIP
  } tgt_state_e;

  localparam logic [3:0] CMD_MEM_RD    = 4'h6;
  localparam logic [3:0] CMD_MEM_WR    = 4'h7;
  localparam logic [3:0] CMD_DUAL_ADDR = 4'hD;

  function automatic logic line_size_ok(input logic [7:0] ls, input int lo_log, input int hi_log);
    logic ok;
    ok = 1'b0;
    for (int i = lo_log; i <= hi_log; i++) begin
      if (ls == (8'd1 << i)) ok = 1'b1;
    end
    return ok;
  endfunction

endpackage

// File: rtl/mbt_decode.sv
module mbt_decode
  import mbt_pkg::*;
#(
  parameter int AW         = 4,
  parameter int CLS_LO_LOG = 2,
  parameter int CLS_HI_LOG = 4
) (
  input  logic [31:0] ad_i,
  input  logic [3:0]  cbe_i,
  input  logic [31:0] win_base_i,
  input  logic [7:0]  line_size_i,
  output logic        hit_o,
  output logic        is_write_o,
  output logic        single_only_o
);

  localparam int LSB = AW + 2;

  logic cmd_ok;
  logic in_window;
  logic unused_low;

  assign cmd_ok        = (cbe_i == CMD_MEM_RD) || (cbe_i == CMD_MEM_WR);
  assign in_window     = (ad_i[31:LSB] == win_base_i[31:LSB]);
  assign hit_o         = cmd_ok && in_window;
  assign is_write_o    = (cbe_i == CMD_MEM_WR);
  assign single_only_o = !line_size_ok(line_size_i, CLS_LO_LOG, CLS_HI_LOG);
  assign unused_low    = ^{ad_i[LSB-1:0], win_base_i[LSB-1:0]};

endmodule

// File: rtl/mbt_mem.sv
module mbt_mem #(
  parameter int WORDS = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_idx_i,
  input  logic [3:0]    wr_be_i,
  input  logic [31:0]   wr_data_i,
  input  logic [AW-1:0] rd_idx_i,
  output logic [31:0]   rd_data_o
);

  for (genvar b = 0; b < 4; b++) begin : g_lane
    logic [7:0] lane_q [WORDS];

    always_ff @(posedge clk) begin
      if (wr_en_i && wr_be_i[b]) begin
        lane_q[wr_idx_i] <= wr_data_i[8*b +: 8];
      end
    end

    assign rd_data_o[8*b +: 8] = lane_q[rd_idx_i];
  end

endmodule

// File: rtl/mbt_parity.sv
module mbt_parity (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        chk_en_i,
  input  logic [31:0] ad_i,
  input  logic [3:0]  cbe_i,
  input  logic        par_i,
  output logic        par_err_o
);

  logic exp_q, exp_d;
  logic vld_q, vld_d;
  logic err_q, err_d;

  always_comb begin
    exp_d = exp_q;
    if (chk_en_i) exp_d = ^{ad_i, cbe_i};
    vld_d = chk_en_i;
    err_d = vld_q && (exp_q != par_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= 1'b0;
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      exp_q <= exp_d;
      vld_q <= vld_d;
      err_q <= err_d;
    end
  end

  assign par_err_o = err_q;

endmodule

// File: rtl/mbt_fsm.sv
module mbt_fsm
  import mbt_pkg::*;
#(
  parameter int WORDS       = 16,
  parameter int AW          = 4,
  parameter int RETRY_EVERY = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ini_active_i,
  input  logic          ini_ready_i,
  input  logic [AW-1:0] addr_idx_i,
  input  logic          hit_i,
  input  logic          is_write_i,
  input  logic          single_only_i,
  input  logic [1:0]    speed_i,
  output logic          claim_o,
  output logic          ready_o,
  output logic          stop_o,
  output logic          rd_oe_o,
  output logic          wr_xfer_o,
  output logic [AW-1:0] idx_o
);

  localparam int RCW = (RETRY_EVERY > 2) ? $clog2(RETRY_EVERY) : 1;
  localparam logic [AW-1:0] LAST_IDX = AW'(WORDS - 1);

  tgt_state_e    state_q, state_d;
  logic [1:0]    wait_q, wait_d;
  logic [AW-1:0] idx_q, idx_d;
  logic          wr_q, wr_d;
  logic          single_q, single_d;
  logic [RCW-1:0] rcnt_q, rcnt_d;

  logic [1:0] lat;
  logic       claim_go;
  logic       retry_now;
  logic       in_data;
  logic       stop_c;

  assign lat       = (speed_i == 2'd3) ? 2'd2 : speed_i;
  assign in_data   = (state_q == ST_DATA);
  assign stop_c    = in_data && (single_q || (idx_q == LAST_IDX));
  assign retry_now = (RETRY_EVERY != 0) && (int'(rcnt_q) == RETRY_EVERY - 1);

  always_comb begin
    state_d  = state_q;
    wait_d   = wait_q;
    idx_d    = idx_q;
    wr_d     = wr_q;
    single_d = single_q;
    rcnt_d   = rcnt_q;
    claim_go = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ini_active_i) begin
          idx_d    = addr_idx_i;
          wr_d     = is_write_i;
          single_d = single_only_i;
          if (!hit_i) begin
            state_d = ST_SKIP;
          end else if (lat == 2'd0) begin
            claim_go = 1'b1;
          end else begin
            state_d = ST_WAIT;
            wait_d  = lat;
          end
        end
      end
      ST_WAIT: begin
        if (wait_q == 2'd1) claim_go = 1'b1;
        else                wait_d   = wait_q - 2'd1;
      end
      ST_DATA: begin
        if (ini_ready_i) begin
          idx_d = idx_q + 1'b1;
          if (!ini_active_i) state_d = ST_IDLE;
          else if (stop_c)   state_d = ST_HOLD;
        end
      end
      ST_RETRY, ST_HOLD, ST_SKIP: begin
        if (!ini_active_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    if (claim_go) begin
      state_d = retry_now ? ST_RETRY : ST_DATA;
      rcnt_d  = retry_now ? '0 : rcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      wait_q   <= 2'd0;
      idx_q    <= '0;
      wr_q     <= 1'b0;
      single_q <= 1'b0;
      rcnt_q   <= '0;
    end else begin
      state_q  <= state_d;
      wait_q   <= wait_d;
      idx_q    <= idx_d;
      wr_q     <= wr_d;
      single_q <= single_d;
      rcnt_q   <= rcnt_d;
    end
  end

  assign claim_o   = in_data || (state_q == ST_RETRY) || (state_q == ST_HOLD);
  assign ready_o   = in_data;
  assign stop_o    = stop_c || (state_q == ST_RETRY) || (state_q == ST_HOLD);
  assign rd_oe_o   = in_data && !wr_q;
  assign wr_xfer_o = in_data && wr_q && ini_ready_i;
  assign idx_o     = idx_q;

endmodule

// File: rtl/mux_bus_target.sv
module mux_bus_target #(
  parameter int MEM_WORDS   = 16,
  parameter int CLS_LO_LOG  = 2,
  parameter int CLS_HI_LOG  = 4,
  parameter int RETRY_EVERY = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ini_active_i,
  input  logic        ini_ready_i,
  input  logic [31:0] ad_i,
  input  logic [3:0]  cbe_i,
  input  logic        par_i,
  input  logic [1:0]  speed_i,
  input  logic [7:0]  line_size_i,
  input  logic [31:0] win_base_i,
  output logic [31:0] ad_o,
  output logic        ad_oe_o,
  output logic        claim_o,
  output logic        tgt_ready_o,
  output logic        tgt_stop_o,
  output logic        par_err_o
);

  localparam int AW = $clog2(MEM_WORDS);

  logic          hit;
  logic          is_write;
  logic          single_only;
  logic          wr_xfer;
  logic [AW-1:0] idx;

  mbt_decode #(
    .AW(AW), .CLS_LO_LOG(CLS_LO_LOG), .CLS_HI_LOG(CLS_HI_LOG)
  ) u_decode (
    .ad_i(ad_i), .cbe_i(cbe_i), .win_base_i(win_base_i), .line_size_i(line_size_i),
    .hit_o(hit), .is_write_o(is_write), .single_only_o(single_only)
  );

  mbt_fsm #(
    .WORDS(MEM_WORDS), .AW(AW), .RETRY_EVERY(RETRY_EVERY)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .ini_active_i(ini_active_i), .ini_ready_i(ini_ready_i),
    .addr_idx_i(ad_i[AW+1:2]), .hit_i(hit), .is_write_i(is_write),
    .single_only_i(single_only), .speed_i(speed_i),
    .claim_o(claim_o), .ready_o(tgt_ready_o), .stop_o(tgt_stop_o),
    .rd_oe_o(ad_oe_o), .wr_xfer_o(wr_xfer), .idx_o(idx)
  );

  mbt_mem #(
    .WORDS(MEM_WORDS), .AW(AW)
  ) u_mem (
    .clk(clk), .wr_en_i(wr_xfer), .wr_idx_i(idx), .wr_be_i(cbe_i),
    .wr_data_i(ad_i), .rd_idx_i(idx), .rd_data_o(ad_o)
  );

  mbt_parity u_parity (
    .clk(clk), .rst_n(rst_n), .chk_en_i(wr_xfer), .ad_i(ad_i), .cbe_i(cbe_i),
    .par_i(par_i), .par_err_o(par_err_o)
  );

endmodule

// File: rtl/mux_bus_target_chk.sv
module mux_bus_target_chk (
  input logic clk,
  input logic rst_n,
  input logic ini_active_i,
  input logic ini_ready_i,
  input logic claim_o,
  input logic tgt_ready_o,
  input logic tgt_stop_o,
  input logic ad_oe_o,
  input logic par_err_o
);

  AST_READY_NEEDS_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_ready_o |-> claim_o); // R3

  AST_OE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe_o |-> tgt_ready_o); // R3

  AST_RELEASE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_ready_o && ini_ready_i && !ini_active_i) |=> (!claim_o && !tgt_stop_o)); // R9

  AST_STOP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_stop_o && !tgt_ready_o && ini_active_i) |=> (tgt_stop_o && claim_o)); // R9

  AST_PERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    par_err_o |-> $past(ini_ready_i && tgt_ready_o && !ad_oe_o, 2)); // R8

endmodule

bind mux_bus_target mux_bus_target_chk u_chk (.*);

// File: tb/mux_bus_target_tb.sv
`timescale 1ns/100ps
module mux_bus_target_tb;

  localparam logic [31:0] BASE = 32'h4000_0000;
  localparam logic [3:0]  RD = 4'h6;
  localparam logic [3:0]  WR = 4'h7;
  localparam int NV = 16;

  typedef struct packed {
    logic [3:0] cmd;
    logic [3:0] widx;
    logic       outside;
    logic [4:0] nw;
    logic [1:0] spd;
    logic [7:0] ls;
    logic [3:0] be;
    logic       bad;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{WR,    4'd0,  1'b0, 5'd16, 2'd0, 8'd16, 4'hF, 1'b0},
    '{RD,    4'd0,  1'b0, 5'd4,  2'd1, 8'd8,  4'h0, 1'b0},
    '{WR,    4'd2,  1'b0, 5'd3,  2'd2, 8'd16, 4'h5, 1'b0},
    '{WR,    4'd8,  1'b0, 5'd2,  2'd0, 8'd8,  4'hF, 1'b0},
    '{RD,    4'd2,  1'b0, 5'd3,  2'd1, 8'd4,  4'h0, 1'b0},
    '{RD,    4'd8,  1'b0, 5'd2,  2'd2, 8'd8,  4'h0, 1'b0},
    '{WR,    4'd14, 1'b0, 5'd4,  2'd0, 8'd8,  4'hF, 1'b0},
    '{RD,    4'd14, 1'b0, 5'd4,  2'd1, 8'd8,  4'h0, 1'b0},
    '{WR,    4'd4,  1'b0, 5'd3,  2'd0, 8'd12, 4'hF, 1'b0},
    '{RD,    4'd4,  1'b0, 5'd3,  2'd2, 8'd0,  4'h0, 1'b0},
    '{WR,    4'd1,  1'b1, 5'd2,  2'd0, 8'd8,  4'hF, 1'b0},
    '{4'hD,  4'd0,  1'b0, 5'd2,  2'd0, 8'd8,  4'hF, 1'b0},
    '{4'h2,  4'd0,  1'b0, 5'd1,  2'd1, 8'd8,  4'h0, 1'b0},
    '{WR,    4'd10, 1'b0, 5'd2,  2'd1, 8'd8,  4'hF, 1'b1},
    '{RD,    4'd0,  1'b0, 5'd16, 2'd3, 8'd16, 4'h0, 1'b0},
    '{RD,    4'd10, 1'b0, 5'd2,  2'd0, 8'd8,  4'h0, 1'b0}
  };

  logic        clk;
  logic        rst_n;
  logic        ini_active, ini_ready, par;
  logic [31:0] ad;
  logic [3:0]  cbe;
  logic [1:0]  speed;
  logic [7:0]  ls;
  logic [31:0] base;
  logic [31:0] ad_o;
  logic        ad_oe_o, claim_o, tgt_ready_o, tgt_stop_o, par_err_o;

  int checks = 0;
  int failures = 0;
  int claim_cnt = 0;
  bit finished = 0;
  logic [31:0] model [16];

  mux_bus_target #(.RETRY_EVERY(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .ini_active_i(ini_active), .ini_ready_i(ini_ready),
    .ad_i(ad), .cbe_i(cbe), .par_i(par), .speed_i(speed), .line_size_i(ls),
    .win_base_i(base), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .claim_o(claim_o),
    .tgt_ready_o(tgt_ready_o), .tgt_stop_o(tgt_stop_o), .par_err_o(par_err_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  function automatic logic [31:0] wdata(input int seed, input int beat);
    return 32'h1000_0000 * seed + 32'h0101_0101 * beat + 32'h00A5_5A00;
  endfunction

  task automatic run_txn(input logic [3:0] cmd, input logic [31:0] addr, input int nw,
                         input logic [3:0] be, input bit bad, input int seed,
                         output int claim_cyc, output int nx, output bit saw_retry,
                         output bit data_err, output bit perr_err);
    bit wr, active, pend, exp_perr, prev_xfer, prev_stop, this_xfer;
    logic pend_par;
    int cyc, tail, widx;
    wr = (cmd == WR);
    claim_cyc = 0; nx = 0; saw_retry = 0; data_err = 0; perr_err = 0;
    pend = 0; exp_perr = 0; prev_xfer = 0; prev_stop = 0; pend_par = 0;
    widx = int'(addr[5:2]);
    @(negedge clk);
    ini_active = 1'b1; ini_ready = 1'b0; ad = addr; cbe = cmd;
    cyc = 1; active = 1; tail = 0;
    while (tail < 3) begin
      @(negedge clk);
      cyc++;
      if (par_err_o !== exp_perr) perr_err = 1;
      exp_perr = pend && bad;
      if (pend) par = pend_par ^ bad;
      pend = 0;
      this_xfer = 0;
      if (active) begin
        if (claim_o && claim_cyc == 0) claim_cyc = cyc;
        if (cyc == 2) begin
          ini_ready = 1'b1; ini_active = (nw > 1);
          ad = wr ? wdata(seed, 0) : 32'h0; cbe = wr ? be : 4'h0;
        end else if (prev_xfer) begin
          if (prev_stop || nx == nw) begin
            ini_active = 1'b0; ini_ready = 1'b0; ad = 32'h0; cbe = 4'h0; active = 0;
          end else begin
            ini_active = (nx < nw - 1);
            ad = wr ? wdata(seed, nx) : 32'h0;
          end
        end else if (claim_o && tgt_stop_o && !tgt_ready_o) begin
          saw_retry = 1;
          ini_active = 1'b0; ini_ready = 1'b0; ad = 32'h0; cbe = 4'h0; active = 0;
        end else if (!claim_o && cyc >= 6) begin
          ini_active = 1'b0; ini_ready = 1'b0; ad = 32'h0; cbe = 4'h0; active = 0;
        end
        this_xfer = active && tgt_ready_o && ini_ready;
        if (this_xfer) begin
          if (wr) begin
            for (int b = 0; b < 4; b++)
              if (be[b]) model[(widx + nx) % 16][8*b +: 8] = ad[8*b +: 8];
            pend = 1; pend_par = ^{ad, cbe};
          end else if (ad_o !== model[(widx + nx) % 16] || !ad_oe_o) begin
            data_err = 1;
          end
          nx++;
        end
        prev_xfer = this_xfer;
        prev_stop = tgt_stop_o;
      end else begin
        tail++;
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "R3", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    int ccyc, nx, exp_nx, exp_cyc, lat, widx;
    bit ret, derr, perr, claimable, exp_retry;
    logic [31:0] a;
    string nreq;
    vec_t t;
    rst_n = 1'b0; ini_active = 1'b0; ini_ready = 1'b0; par = 1'b0;
    ad = 32'h0; cbe = 4'h0; speed = 2'd0; ls = 8'd8; base = BASE;
    repeat (3) @(negedge clk);
    chk({claim_o, tgt_ready_o, tgt_stop_o, ad_oe_o, par_err_o} == 5'b0, "R10", "outputs in reset",
        int'({claim_o, tgt_ready_o, tgt_stop_o, ad_oe_o, par_err_o}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({claim_o, tgt_ready_o, tgt_stop_o, par_err_o} == 4'b0, "R10", "outputs after reset",
        int'({claim_o, tgt_ready_o, tgt_stop_o, par_err_o}), 0);

    for (int v = 0; v < NV; v++) begin
      t = VECS[v];
      widx = int'(t.widx);
      a = (t.outside ? (BASE + 32'h40) : BASE) | {26'h0, t.widx, 2'b00};
      speed = t.spd; ls = t.ls;
      claimable = !t.outside && (t.cmd == RD || t.cmd == WR);
      lat = (t.spd == 2'd3) ? 2 : int'(t.spd);
      do begin
        if (claimable) claim_cnt++;
        exp_retry = claimable && (claim_cnt % 4 == 0);
        run_txn(t.cmd, a, int'(t.nw), t.be, t.bad, v + 1, ccyc, nx, ret, derr, perr);
        exp_cyc = claimable ? 2 + lat : 0;
        chk(ccyc == exp_cyc, claimable ? "R1" : "R2", "claim clock", ccyc, exp_cyc);
        chk(ret == exp_retry, "R7", "retry seen", int'(ret), int'(exp_retry));
        nreq = "R3";
        if (!claimable || exp_retry) exp_nx = 0;
        else if (!(t.ls == 8'd4 || t.ls == 8'd8 || t.ls == 8'd16)) begin exp_nx = 1; nreq = "R6"; end
        else if (16 - widx < int'(t.nw)) begin exp_nx = 16 - widx; nreq = "R5"; end
        else exp_nx = int'(t.nw);
        if (exp_retry) nreq = "R7";
        chk(nx == exp_nx, nreq, "words moved", nx, exp_nx);
        chk(!derr, "R4", "read data at linear addresses", int'(derr), 0);
        chk(!perr, "R8", "parity error flag timing", int'(perr), 0);
      end while (exp_retry);
    end

    chk({claim_o, tgt_ready_o, tgt_stop_o} == 3'b0, "R9", "idle after last transfer",
        int'({claim_o, tgt_ready_o, tgt_stop_o}), 0);

    // R2: moving the window base moves the claimed range
    base = 32'h8000_0000; speed = 2'd0; ls = 8'd8;
    claim_cnt++;
    run_txn(RD, 32'h8000_000C, 2, 4'h0, 0, 40, ccyc, nx, ret, derr, perr);
    chk(ccyc == 2 && nx == 2 && !derr, "R2", "claim at new base", nx, 2);
    run_txn(RD, BASE | 32'hC, 2, 4'h0, 0, 41, ccyc, nx, ret, derr, perr);
    chk(ccyc == 0 && nx == 0, "R2", "old base ignored", ccyc, 0);
    base = BASE;

    repeat (3) @(negedge clk);
    summary();
  end

endmodule